// File: doc/BRIEF.md
# Iterative Conditional-Subtract Divider

This block divides one unsigned 16-bit operand by another. It returns the quotient and the remainder together. All of its state is a single 32-bit accumulator. When a run starts, the zero-extended dividend goes into the accumulator. A second register holds the divisor moved up by fifteen bit positions.

On every clock the block tries to subtract that shifted divisor from the accumulator:

- If the result is not negative, the accumulator takes the result shifted left by one with a 1 in the lowest bit.
- Otherwise the accumulator shifts left by one and takes a 0.

After sixteen of these identical one-cycle steps, the low half of the accumulator is the quotient and the high half is the remainder.

A user pulses `start` with the operands present. The user then waits for the one-cycle `done` pulse and reads `quotient` and `remainder`. Both outputs stay valid until the next accepted start. A divisor of zero needs no special handling: the same sixteen steps give an all-ones quotient and return the dividend as the remainder.

Top module: `csub_divider`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `quotient` and `remainder` are 0.
- R2: For a nonzero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor when `done` is high.
- R3: Each division keeps `busy` high for exactly 16 clock cycles. `done` rises in the cycle that follows the last of them.
- R4: `done` is high for a single cycle, and `busy` is low whenever `done` is high.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The run in progress finishes with the results of its own operands.
- R6: Once `done` has been seen, `quotient` and `remainder` hold their values until the next accepted `start`.
- R7: A divisor of zero gives a quotient of 0xFFFF and a remainder equal to the dividend, after the usual 16 cycles.
- R8: A `start` that is sampled while `busy` is low is accepted, and `busy` is high in the next cycle. This includes a `start` given in the same cycle as `done`.
- R9: Boundary operands give exact results. A dividend of 0 gives 0 remainder 0. A divisor of 1 gives the dividend remainder 0. 0xFFFF/0xFFFF gives 1 remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when not busy |
| dividend | input | 16 | Unsigned dividend, sampled at an accepted start |
| divisor | input | 16 | Unsigned divisor, sampled at an accepted start |
| busy | output | 1 | High while the 16 steps run |
| done | output | 1 | One-cycle pulse when results are ready |
| quotient | output | 16 | Low half of the accumulator |
| remainder | output | 16 | High half of the accumulator |

## Verification
The assertions assume that `start` is a clean synchronous level and that the operands are stable at the edge where a start is accepted. They do not assume the operands stay put during a run, because the block copies them at that edge. The bounds check on the accumulator relies on the divisor being nonzero. That check is gated on the shifted divisor register and never on the live input. The stimulus changes inputs only on falling edges and releases `start` one cycle after raising it. It raises `start` deliberately in the middle of a run to exercise the ignore path, and its random operand pairs include a zero divisor.

// File: rtl/csub_divider.sv
module csub_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int AW = 2 * W;
  localparam int CW = $clog2(W);

  logic [AW-1:0] acc;
  logic [AW-1:0] sub;
  logic [AW:0]   diff;
  logic [CW-1:0] step;
  logic          accept;

  assign accept = start && !busy;
  assign diff   = {1'b0, acc} - {1'b0, sub};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      sub  <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        acc  <= {{W{1'b0}}, dividend};
        sub  <= {{W{1'b0}}, divisor} << (W - 1);
        step <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (!diff[AW]) acc <= {diff[AW-2:0], 1'b1};
        else           acc <= {acc[AW-2:0], 1'b0};
        step <= step + 1'b1;
        if (step == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = acc[W-1:0];
  assign remainder = acc[AW-1:W];

  // Assertion support: count busy cycles of the current run.
  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (accept) run_len <= '0;
    else if (busy)   run_len <= run_len + 1'b1;
  end

  a_r3_sixteen_steps: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == (CW+1)'(W));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(sub));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2: partial remainder stays below twice the shifted divisor, so no bit is lost
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sub != '0) |-> ({1'b0, acc} < {sub, 1'b0}));

  a_r2_shift_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !diff[AW]) |-> !diff[AW-1]);
endmodule

// File: tb/csub_divider_test.sv
module csub_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done;
  logic [15:0] quotient, remainder;

  int tests = 0;
  int fails = 0;
  int run_cycles = 0;
  logic [31:0] sb_q[$];
  logic [31:0] last_exp = '0;

  always #4 clk = ~clk;

  csub_divider #(.W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b);
    if (b == 0) return {a, 16'hFFFF};
    return {a % b, a / b};
  endfunction

  // Monitor: compare results and run length on each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run_cycles++;
      if (done) begin
        check("R3 busy length", run_cycles == 16, 32'(run_cycles), 32'd16);
        check("R4 busy low at done", !busy, {31'b0, busy}, 32'd0);
        if (sb_q.size() == 0) begin
          check("R2 unexpected done", 1'b0, {remainder, quotient}, 32'hx);
        end else begin
          last_exp = sb_q.pop_front();
          check("R2/R7/R9 result", {remainder, quotient} == last_exp,
                {remainder, quotient}, last_exp);
        end
        run_cycles = 0;
      end
    end
  end

  task automatic divide(input logic [15:0] a, input logic [15:0] b);
    sb_q.push_back(model(a, b));
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, {31'b0, busy}, 32'd1);
    while (!done) @(negedge clk);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, done, quotient, remainder} == 34'd0,
          {remainder, quotient}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    divide(16'd47, 16'd6);
    divide(16'd0, 16'd77);       // R9
    divide(16'd4321, 16'd1);     // R9
    divide(16'hFFFF, 16'hFFFF);  // R9
    divide(16'hFFFF, 16'd1);     // R9
    divide(16'd5, 16'd9);        // R2 divisor above dividend
    divide(16'd1234, 16'd0);     // R7
    divide(16'hFFFF, 16'd0);     // R7

    // R6: results hold while idle
    repeat (5) @(negedge clk);
    check("R6 hold", {remainder, quotient} == last_exp, {remainder, quotient}, last_exp);
    check("R4 done single", !done, {31'b0, done}, 32'd0);

    // R5: start during busy is ignored
    sb_q.push_back(model(16'd1000, 16'd7));
    dividend = 16'd1000; divisor = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    dividend = 16'd9; divisor = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dividend = 16'd0; divisor = 16'd0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R5 ignored start", !busy && sb_q.size() == 0,
          {31'b0, busy}, 32'd0);

    // R8: back-to-back start in the done cycle
    sb_q.push_back(model(16'd300, 16'd17));
    dividend = 16'd300; divisor = 16'd17; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    sb_q.push_back(model(16'd999, 16'd10));
    dividend = 16'd999; divisor = 16'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 start at done", busy, {31'b0, busy}, 32'd1);
    while (!done) @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = (i % 8 == 3) ? 16'd0 : 16'($urandom >> (i % 16));
      divide(a, b);
    end

    repeat (3) @(negedge clk);
    check("R2 queue drained", sb_q.size() == 0, 32'(sb_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule